// File: doc/BRIEF.md
# Open-Row DRAM Bank Sequencer

This block drives the command side of one DRAM bank and leaves the row buffer open between accesses. Each request arrives on a valid/ready handshake with a row, a column and a write flag. The sequencer turns it into the shortest legal series of commands. A request to a closed bank gets an activate and then the column command. A request to the row that is already open gets the column command alone. A request to any other row gets a precharge, an activate and then the column command. Every interval between commands is a parameter counted in clock cycles, and each wait state runs on one shared down-counter.

Each finished request raises a one-cycle completion pulse on the cycle its column command goes out, with a flag that marks a row hit. The pulse goes to the requester. A refresh input ends the open-row state. The sequencer lets the access in flight finish, closes any open row, and then holds a grant until the refresh input falls. During that time no new request is accepted. Write data is outside this block, and every timing parameter must be at least 2.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset the bank is closed, `req_ready` is 1, and `cmd_valid`, `ref_grant` and `done` are 0.
- R2: A request accepted while no row is open issues ACTIVATE with the request's row on the cycle after acceptance, then the column command exactly T_RCD cycles later, with `done_hit` 0.
- R3: A request whose row equals the open row issues no ACTIVATE and no PRECHARGE, puts its column command out on the cycle after acceptance, and reports `done_hit` 1.
- R4: A request to a different row issues PRECHARGE carrying the old row on the cycle after acceptance, ACTIVATE of the new row exactly T_RP cycles later, and the column command T_RCD cycles after that, with `done_hit` 0. No ACTIVATE follows a PRECHARGE by fewer than T_RP cycles.
- R5: A write issues `cmd_op` 2 and `req_ready` returns exactly T_WR cycles after the write command. No PRECHARGE follows a write by fewer than T_WR cycles.
- R6: A read issues `cmd_op` 1 and `req_ready` returns exactly T_BURST cycles after the read command.
- R7: When `ref_req` is seen while idle with a row open, PRECHARGE of that row follows on the next cycle and `ref_grant` rises T_RP cycles after it. When the bank is closed, `ref_grant` rises on the next cycle with no command. The grant holds with no command output while `ref_req` stays high. After release the bank is closed, so the next request to the previous row is served as in R2.
- R8: `req_ready` is 1 only while idle and `ref_req` is low. A request offered while `ref_req` is high is not taken and emits no column command.
- R9: `done` is a one-cycle pulse that coincides with the read or write column command and carries that command's column on `cmd_col`.
- R10: Command encoding on `cmd_op`: ACTIVATE 0, READ 1, WRITE 2, PRECHARGE 3. A column command carries `cmd_row`/`cmd_col` of the request, and no column command issues closer than T_RCD cycles after ACTIVATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_row | input | ROW_W | Request row address |
| req_col | input | COL_W | Request column address |
| req_write | input | 1 | 1 for write, 0 for read |
| ref_req | input | 1 | Refresh wanted; held until done |
| ref_grant | output | 1 | Bank closed and handed to refresh |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 2 | Command code (see R10) |
| cmd_row | output | ROW_W | Row of ACTIVATE/PRECHARGE/column command |
| cmd_col | output | COL_W | Column of the column command |
| done | output | 1 | Request completed (column command cycle) |
| done_hit | output | 1 | Completed request was a row hit |

## Verification
The main stimulus is a stream of requests that moves the bank through its three paths. It opens the first row from closed, follows with a run of hits that mixes reads and writes, and then forces misses, including one just after a write, and misses to row 0 and to the highest row. The position of each column command after acceptance shows whether the closed, hit or miss path was taken. The wait before ready returns shows read bursts apart from write recovery. Directed refresh cases, one with a row open and one with the bank closed, check that a request offered during refresh is ignored. They also check that the first access after refresh pays for an activate again.

// File: rtl/dram_bank_seq.sv
module dram_bank_seq #(
  parameter int ROW_W   = 8,
  parameter int COL_W   = 6,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 4,
  parameter int T_WR    = 5,
  parameter int T_BURST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_write,
  input  logic             ref_req,
  output logic             ref_grant,
  output logic             cmd_valid,
  output logic [1:0]       cmd_op,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             done,
  output logic             done_hit
);
  localparam int TA   = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int TB   = (T_WR > T_BURST) ? T_WR : T_BURST;
  localparam int TMAX = (TA > TB) ? TA : TB;
  localparam int CW   = $clog2(TMAX + 1);

  localparam logic [1:0] OP_ACT = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_WR  = 2'd2;
  localparam logic [1:0] OP_PRE = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_WRP, S_ACT, S_WRCD, S_COL, S_WCOL, S_REF
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic             open_vld;
  logic [ROW_W-1:0] open_row;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic             hit_q;
  logic             ref_q;

  wire is_hit = open_vld && (req_row == open_row);

  assign req_ready = (st == S_IDLE) && !ref_req;
  assign ref_grant = (st == S_REF);
  assign cmd_valid = (st == S_PRE) || (st == S_ACT) || (st == S_COL);
  assign cmd_row   = (st == S_PRE) ? open_row : row_q;
  assign cmd_col   = col_q;
  assign done      = (st == S_COL);
  assign done_hit  = done && hit_q;

  always_comb begin
    case (st)
      S_PRE:   cmd_op = OP_PRE;
      S_COL:   cmd_op = wr_q ? OP_WR : OP_RD;
      default: cmd_op = OP_ACT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      open_vld <= 1'b0;
      open_row <= '0;
      row_q    <= '0;
      col_q    <= '0;
      wr_q     <= 1'b0;
      hit_q    <= 1'b0;
      ref_q    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (ref_req) begin
            ref_q <= 1'b1;
            st    <= open_vld ? S_PRE : S_REF;
          end else if (req_valid) begin
            row_q <= req_row;
            col_q <= req_col;
            wr_q  <= req_write;
            hit_q <= is_hit;
            st    <= !open_vld ? S_ACT : (is_hit ? S_COL : S_PRE);
          end
        end
        S_PRE: begin
          open_vld <= 1'b0;
          cnt      <= CW'(T_RP - 1);
          st       <= S_WRP;
        end
        S_WRP: begin
          if (cnt <= 1) st <= ref_q ? S_REF : S_ACT;
          else          cnt <= cnt - 1'b1;
        end
        S_ACT: begin
          open_vld <= 1'b1;
          open_row <= row_q;
          cnt      <= CW'(T_RCD - 1);
          st       <= S_WRCD;
        end
        S_WRCD: begin
          if (cnt <= 1) st <= S_COL;
          else          cnt <= cnt - 1'b1;
        end
        S_COL: begin
          cnt <= wr_q ? CW'(T_WR - 1) : CW'(T_BURST - 1);
          st  <= S_WCOL;
        end
        S_WCOL: begin
          if (cnt <= 1) st <= S_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        S_REF: begin
          if (!ref_req) begin
            ref_q <= 1'b0;
            st    <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_bank_seq_chk.sv
module dram_bank_seq_chk #(
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  parameter int T_RCD = 3,
  parameter int T_RP  = 4,
  parameter int T_WR  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             ref_grant,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [ROW_W-1:0] cmd_row,
  input logic [COL_W-1:0] cmd_col,
  input logic             done
);
  logic [15:0] since_pre, since_act, since_wr;
  logic        seen_pre, seen_act, seen_wr;

  wire is_pre = cmd_valid && cmd_op == 2'd3;
  wire is_act = cmd_valid && cmd_op == 2'd0;
  wire is_col = cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd2);
  wire is_wr  = cmd_valid && cmd_op == 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pre <= '0; since_act <= '0; since_wr <= '0;
      seen_pre  <= 1'b0; seen_act <= 1'b0; seen_wr <= 1'b0;
    end else begin
      since_pre <= is_pre ? 16'd1 : (since_pre == 16'hFFFF ? since_pre : since_pre + 16'd1);
      since_act <= is_act ? 16'd1 : (since_act == 16'hFFFF ? since_act : since_act + 16'd1);
      since_wr  <= is_wr  ? 16'd1 : (since_wr  == 16'hFFFF ? since_wr  : since_wr  + 16'd1);
      if (is_pre) seen_pre <= 1'b1;
      if (is_act) seen_act <= 1'b1;
      if (is_wr)  seen_wr  <= 1'b1;
    end
  end

  assert_act_after_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && seen_pre) |-> since_pre >= 16'(T_RP));

  assert_col_after_act_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (seen_act && since_act >= 16'(T_RCD)));

  assert_pre_after_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && seen_wr) |-> since_wr >= 16'(T_WR));

  assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cmd_valid && !ref_grant));

  assert_grant_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |-> !cmd_valid);

  assert_done_on_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> is_col);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dram_bank_seq dram_bank_seq_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ref_grant(ref_grant),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col),
  .done(done)
);

// File: tb/tb_dram_bank_seq.sv
module tb_dram_bank_seq;
  localparam int ROW_W = 8, COL_W = 6;
  localparam int T_RCD = 3, T_RP = 4, T_WR = 5, T_BURST = 4;
  localparam int OP_ACT = 0, OP_RD = 1, OP_WR = 2, OP_PRE = 3;
  localparam int NV = 10;
  localparam int V_ROW [NV] = '{5, 5, 5, 9, 9, 3, 3, 0, 255, 255};
  localparam int V_COL [NV] = '{0, 1, 2, 10, 11, 20, 21, 5, 7, 63};
  localparam int V_WR  [NV] = '{0, 1, 0, 0, 1, 1, 0, 0, 0, 1};
  localparam int V_KIND[NV] = '{0, 1, 1, 2, 1, 2, 1, 2, 2, 1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ready, ref_grant, cmd_valid, done, done_hit;
  logic [1:0] cmd_op;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;

  always #5 clk = ~clk;

  dram_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RP(T_RP),
                  .T_WR(T_WR), .T_BURST(T_BURST)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_write(req_write),
    .ref_req(ref_req), .ref_grant(ref_grant), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .done(done), .done_hit(done_hit));

  int checks = 0, fails = 0;
  int open_exp = -1;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int cyc = 0, t_pre = 0, t_act = 0, t_wr = 0;
  bit any_pre = 0, any_act = 0, any_wr = 0;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      cyc++;
      if (cmd_valid) begin
        if (cmd_op == OP_ACT) begin
          if (any_pre) chk(cyc - t_pre >= T_RP, "R4 PRE->ACT gap", cyc - t_pre, T_RP);
          t_act = cyc; any_act = 1;
        end
        if (cmd_op == OP_PRE) begin
          if (any_wr) chk(cyc - t_wr >= T_WR, "R5 WR->PRE gap", cyc - t_wr, T_WR);
          t_pre = cyc; any_pre = 1;
        end
        if (cmd_op == OP_RD || cmd_op == OP_WR) begin
          chk(any_act && cyc - t_act >= T_RCD, "R10 ACT->column gap", cyc - t_act, T_RCD);
          if (cmd_op == OP_WR) begin t_wr = cyc; any_wr = 1; end
        end
      end
    end
  end

  task automatic do_req(int row, int col, int wr, int kind);
    int col_idx, n_act, n_pre, got_hit, rec, exp_idx, exp_rec;
    bit rdy_seen;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_row = ROW_W'(row); req_col = COL_W'(col); req_write = wr[0];
    @(negedge clk);
    req_valid = 1'b0;
    col_idx = -1; n_act = 0; n_pre = 0; got_hit = 0; rdy_seen = 0;
    for (int idx = 0; idx < 200; idx++) begin
      #1;
      if (req_ready) rdy_seen = 1;
      if (cmd_valid && cmd_op == OP_PRE) begin
        n_pre++;
        chk(int'(cmd_row) == open_exp, "R4 PRE carries old row", int'(cmd_row), open_exp);
      end
      if (cmd_valid && cmd_op == OP_ACT) begin
        n_act++;
        chk(int'(cmd_row) == row, "R2 ACT carries new row", int'(cmd_row), row);
      end
      if (done) begin
        col_idx = idx; got_hit = done_hit;
        chk(cmd_valid && int'(cmd_op) == (wr ? OP_WR : OP_RD), "R10 column op code", int'(cmd_op), wr ? OP_WR : OP_RD);
        chk(int'(cmd_col) == col && int'(cmd_row) == row, "R9 column address", int'(cmd_col), col);
        break;
      end
      @(negedge clk);
    end
    exp_idx = (kind == 0) ? T_RCD : (kind == 1) ? 0 : T_RP + T_RCD;
    chk(col_idx == exp_idx, kind == 0 ? "R2 column latency" : kind == 1 ? "R3 column latency" : "R4 column latency", col_idx, exp_idx);
    chk(got_hit == (kind == 1), "R3 hit flag", got_hit, kind == 1);
    chk(n_act == (kind == 1 ? 0 : 1), "R3 activate count", n_act, kind == 1 ? 0 : 1);
    chk(n_pre == (kind == 2 ? 1 : 0), "R4 precharge count", n_pre, kind == 2 ? 1 : 0);
    chk(!rdy_seen, "R8 ready low during access", rdy_seen, 0);
    rec = 0;
    do begin
      @(negedge clk); #1; rec++;
      if (rec == 1) chk(!done, "R9 done one cycle", done, 0);
    end while (!req_ready && rec < 100);
    exp_rec = wr ? T_WR : T_BURST;
    chk(rec == exp_rec, wr ? "R5 write recovery" : "R6 read burst", rec, exp_rec);
    open_exp = row;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R8 progress actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1, "R1 reset ready", req_ready, 1);
    chk(!cmd_valid && !ref_grant && !done, "R1 reset quiet", {cmd_valid, ref_grant, done}, 0);

    for (int i = 0; i < NV; i++) do_req(V_ROW[i], V_COL[i], V_WR[i], V_KIND[i]);

    // R7 refresh with row 255 open; request offered meanwhile must be ignored (R8)
    @(negedge clk);
    ref_req = 1'b1; req_valid = 1'b1; req_row = 8'd255; req_col = 6'd3; req_write = 1'b0;
    #1;
    chk(req_ready == 0, "R8 ready drops on refresh", req_ready, 0);
    for (int idx = 0; idx <= T_RP + 2; idx++) begin
      @(negedge clk); #1;
      if (idx == 0) begin
        chk(cmd_valid && cmd_op == OP_PRE, "R7 refresh precharge", int'(cmd_op), OP_PRE);
        chk(int'(cmd_row) == 255, "R7 precharge row", int'(cmd_row), 255);
      end else begin
        chk(!cmd_valid && !done, "R8 no command during refresh", cmd_valid, 0);
      end
      chk(ref_grant == (idx >= T_RP), "R7 grant timing", ref_grant, idx >= T_RP);
    end
    ref_req = 1'b0; req_valid = 1'b0;
    open_exp = -1;
    do_req(255, 1, 0, 0);

    // R7 refresh with bank closed after a precharging miss is impossible; close via refresh first
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ref_req = 1'b1;
    repeat (T_RP + 1) @(negedge clk);
    ref_req = 1'b0;
    @(negedge clk);
    ref_req = 1'b1;
    @(negedge clk); #1;
    chk(ref_grant == 1 && !cmd_valid, "R7 closed-bank grant", ref_grant, 1);
    @(negedge clk);
    ref_req = 1'b0;
    do_req(7, 9, 1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule